// File: doc/BRIEF.md
# Two-Level Aperture Address Translator

This block turns bus addresses that land inside a graphics aperture window into physical addresses. The window starts at a programmable 4 MB-aligned base and spans one of four sizes. The address bits above bit 21, taken relative to the base, pick a slot in a 64-slot on-chip directory. Each loaded slot points at a 4 KB second-level table in system memory that holds 1024 four-byte entries. Address bits 21:12 pick the entry within that table. The entry's upper 20 bits give the physical page frame, and bit 0 says whether the mapping is live.

Software sets the block up through one 32-bit configuration write port with four targets: the aperture size code, the aperture base, a control word and the directory load word. Translation requests arrive on a valid/ready port. Each one gets exactly one single-cycle response pulse with either a physical address or a fault flag. A four-entry fully associative cache holds recent page translations. On a miss the block reads one second-level entry over a single-beat memory read port, and it never has more than one such read outstanding. Software must flush the cache after it changes any mapping. The flush sequence writes the control word with bit 7 clear and then with bit 7 set, for example 0x2200 followed by 0x2280.

Top module: `aper_xlate`

## Requirements
- R1: After reset the block shows `req_ready`=1, `rsp_valid`=0 and `mem_rd_en`=0. The cache is empty, every directory slot is absent, the size code is 0 and the base is 0.
- R2: A configuration write with `cfg_sel`=3 loads a directory slot. Bits 5:0 select the slot, bit 8 is the present flag, bits 11:9 are an attribute index and bits 31:12 are the table page. Bits 7:6 are ignored. A walk through a present slot reads memory address {table page, request bits 21:12, 2'b00}.
- R3: A translation through an absent slot faults without a memory read. A directory load with bit 8 clear makes the slot absent, and this takes effect even for pages that are already cached.
- R4: The directory index is request bits 31:22 minus base bits 31:22, modulo 1024. The base is written with `cfg_sel`=1 and its bits 31:22 are kept. An address below the base, or an index at or above the slot count, faults without a memory read. This check comes before the cache.
- R5: The size code is written with `cfg_sel`=0 from data bits 7:0. Codes 0, 32, 48 and 56 give 64, 32, 16 and 8 usable slots, which is 256, 128, 64 and 32 MB. Any other code gives no usable slots.
- R6: A second-level entry with bit 0 clear produces a fault response, and the fault is not cached. Every fault response carries `rsp_paddr`=0.
- R7: A live entry returns {entry bits 31:12, request bits 11:0}. The response pulse comes in the cycle after `mem_rd_valid`, which makes a miss three cycles from acceptance to response.
- R8: A cached page responds in the cycle after acceptance, without a memory read.
- R9: The cache holds four pages and replaces them in round-robin fill order. A fifth distinct page evicts the oldest fill.
- R10: A control write (`cfg_sel`=2) with data bit 7 set, while the stored bit 7 is 0, empties the cache. A bit 7 write while the stored bit 7 is already 1 does not empty it.
- R11: A request accepted in the same cycle as a flush is treated as a miss and walks memory.
- R12: Only one walk is in flight. `req_ready` is low from the accept of a miss until its response. `mem_rd_en` is a one-cycle pulse per walk. Each accepted request gets exactly one `rsp_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 0 size, 1 base, 2 control, 3 directory load |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Bus address to translate |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_fault | output | 1 | Translation failed |
| rsp_paddr | output | 32 | Physical address, zero on fault |
| mem_rd_en | output | 1 | Second-level entry read pulse |
| mem_rd_addr | output | 32 | Byte address of the entry read |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Second-level entry |

## Verification
The assertions take three things for granted. Memory raises `mem_rd_valid` only once, in some cycle after the `mem_rd_en` pulse, and never while no walk is waiting. The requester holds `req_valid` only when it means a new request. Configuration writes are single-cycle strobes. The bench memory model meets the first condition by answering exactly one cycle after each read pulse. The request tasks raise `req_valid` for one cycle, only while `req_ready` is high. Configuration writes are issued one cycle at a time, and one scenario deliberately lines a flush write up with a request acceptance.

// File: rtl/aper_pkg.sv
`timescale 1ns/1ps
package aper_pkg;

  typedef enum logic [1:0] {
    SEL_SIZE = 2'd0,
    SEL_BASE = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_DIR  = 2'd3
  } cfg_sel_e;

  typedef enum logic [1:0] {
    WK_IDLE  = 2'd0,
    WK_ISSUE = 2'd1,
    WK_WAIT  = 2'd2
  } walk_st_e;

  typedef struct packed {
    logic        present;
    logic [2:0]  attr;
    logic [19:0] pfn;
  } dir_ent_t;

  // usable directory slots for each aperture size code
  function automatic logic [6:0] slots_for_code(input logic [7:0] code);
    logic [6:0] n;
    case (code)
      8'd0:    n = 7'd64;
      8'd32:   n = 7'd32;
      8'd48:   n = 7'd16;
      8'd56:   n = 7'd8;
      default: n = 7'd0;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/aper_regs.sv
`timescale 1ns/1ps
module aper_regs
  import aper_pkg::*;
#(
  parameter int DIR_ENTRIES = 64,
  localparam int IDX_W = (DIR_ENTRIES > 1) ? $clog2(DIR_ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [31:0]      cfg_wdata,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       size_code,
  output logic [9:0]       base_hi,
  output logic             ctrl_armed,
  output logic             flush,
  output dir_ent_t         rd_ent
);

  logic       size_we, base_we, ctrl_we, dir_we;
  logic [7:0] size_q, size_d;
  logic [9:0] base_q, base_d;
  logic       arm_q, arm_d;

  assign size_we = cfg_we && (cfg_sel == SEL_SIZE);
  assign base_we = cfg_we && (cfg_sel == SEL_BASE);
  assign ctrl_we = cfg_we && (cfg_sel == SEL_CTRL);
  assign dir_we  = cfg_we && (cfg_sel == SEL_DIR);

  always_comb begin
    size_d = size_q;
    base_d = base_q;
    arm_d  = arm_q;
    if (size_we) size_d = cfg_wdata[7:0];
    if (base_we) base_d = cfg_wdata[31:22];
    if (ctrl_we) arm_d  = cfg_wdata[7];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= '0;
      base_q <= '0;
      arm_q  <= 1'b0;
    end else begin
      size_q <= size_d;
      base_q <= base_d;
      arm_q  <= arm_d;
    end
  end

  // flush fires on the 0 -> 1 step of the stored control bit 7
  assign flush      = ctrl_we && cfg_wdata[7] && !arm_q;
  assign size_code  = size_q;
  assign base_hi    = base_q;
  assign ctrl_armed = arm_q;

  // on-chip directory
  logic [DIR_ENTRIES-1:0] pres_q;
  logic [19:0]            pfn_q  [DIR_ENTRIES];
  logic [2:0]             attr_q [DIR_ENTRIES];

  for (genvar g = 0; g < DIR_ENTRIES; g++) begin : g_dir
    logic slot_we;
    assign slot_we = dir_we && (cfg_wdata[IDX_W-1:0] == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pres_q[g] <= 1'b0;
      end else if (slot_we) begin
        pres_q[g] <= cfg_wdata[8];
      end
    end

    always_ff @(posedge clk) begin
      if (slot_we && cfg_wdata[8]) begin
        pfn_q[g]  <= cfg_wdata[31:12];
        attr_q[g] <= cfg_wdata[11:9];
      end
    end
  end

  always_comb begin
    rd_ent.present = pres_q[rd_idx];
    rd_ent.attr    = attr_q[rd_idx];
    rd_ent.pfn     = pfn_q[rd_idx];
  end

endmodule

// File: rtl/aper_tlb.sv
`timescale 1ns/1ps
module aper_tlb #(
  parameter int ENTRIES = 4,
  parameter int TAG_W   = 20,
  parameter int PFN_W   = 20,
  localparam int PTR_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic [TAG_W-1:0]   lk_tag,
  output logic               hit,
  output logic [PFN_W-1:0]   hit_pfn,
  input  logic               fill_en,
  input  logic [TAG_W-1:0]   fill_tag,
  input  logic [PFN_W-1:0]   fill_pfn,
  output logic [ENTRIES-1:0] vld
);

  logic [ENTRIES-1:0] vld_q, vld_d, match;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q [ENTRIES];
  logic [PTR_W-1:0]   ptr_q, ptr_d;
  logic               do_fill;

  // flush wins over a fill in the same cycle
  assign do_fill = fill_en && !flush;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_way
    logic way_we;
    assign way_we   = do_fill && (ptr_q == PTR_W'(g));
    assign match[g] = vld_q[g] && (tag_q[g] == lk_tag);

    always_ff @(posedge clk) begin
      if (way_we) begin
        tag_q[g] <= fill_tag;
        pfn_q[g] <= fill_pfn;
      end
    end
  end

  always_comb begin
    vld_d = vld_q;
    ptr_d = ptr_q;
    if (flush) begin
      vld_d = '0;
    end else if (fill_en) begin
      vld_d[ptr_q] = 1'b1;
      ptr_d = (ptr_q == PTR_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else begin
      vld_q <= vld_d;
      ptr_q <= ptr_d;
    end
  end

  always_comb begin
    hit_pfn = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) hit_pfn = hit_pfn | pfn_q[i];
    end
  end

  assign hit = (|match) && !flush;
  assign vld = vld_q;

endmodule

// File: rtl/aper_walk.sv
`timescale 1ns/1ps
module aper_walk
  import aper_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_addr,
  output logic        req_ready,
  input  logic        in_range,
  input  dir_ent_t    dir_ent,
  input  logic        tlb_hit,
  input  logic [19:0] tlb_pfn,
  input  logic        flush,
  output logic        mem_rd_en,
  output logic [31:0] mem_rd_addr,
  input  logic        mem_rd_valid,
  input  logic [31:0] mem_rd_data,
  output logic        rsp_valid,
  output logic        rsp_fault,
  output logic [31:0] rsp_paddr,
  output logic        fill_en,
  output logic [19:0] fill_tag,
  output logic [19:0] fill_pfn
);

  walk_st_e    st_q, st_d;
  logic [31:0] addr_q, rda_q;
  logic        kill_q, kill_d;
  logic        rv_q, rv_d, rf_q, rf_d;
  logic [31:0] rp_q, rp_d;
  logic        walk_start;
  logic        unused_bits;

  assign unused_bits = ^{dir_ent.attr, mem_rd_data[11:1]};

  assign walk_start = (st_q == WK_IDLE) && req_valid && in_range &&
                      dir_ent.present && !tlb_hit;

  always_comb begin
    st_d    = st_q;
    kill_d  = kill_q;
    rv_d    = 1'b0;
    rf_d    = 1'b0;
    rp_d    = '0;
    fill_en = 1'b0;
    unique case (st_q)
      WK_IDLE: begin
        if (req_valid) begin
          if (!in_range || !dir_ent.present) begin
            rv_d = 1'b1;
            rf_d = 1'b1;
          end else if (tlb_hit) begin
            rv_d = 1'b1;
            rp_d = {tlb_pfn, req_addr[11:0]};
          end else begin
            st_d   = WK_ISSUE;
            kill_d = 1'b0;
          end
        end
      end
      WK_ISSUE: begin
        st_d = WK_WAIT;
        if (flush) kill_d = 1'b1;
      end
      WK_WAIT: begin
        if (flush) kill_d = 1'b1;
        if (mem_rd_valid) begin
          rv_d = 1'b1;
          st_d = WK_IDLE;
          if (mem_rd_data[0]) begin
            rp_d    = {mem_rd_data[31:12], addr_q[11:0]};
            fill_en = !kill_q && !flush;
          end else begin
            rf_d = 1'b1;
          end
        end
      end
      default: st_d = WK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= WK_IDLE;
      kill_q <= 1'b0;
      rv_q   <= 1'b0;
      rf_q   <= 1'b0;
      rp_q   <= '0;
    end else begin
      st_q   <= st_d;
      kill_q <= kill_d;
      rv_q   <= rv_d;
      rf_q   <= rf_d;
      rp_q   <= rp_d;
    end
  end

  always_ff @(posedge clk) begin
    if (walk_start) begin
      addr_q <= req_addr;
      rda_q  <= {dir_ent.pfn, req_addr[21:12], 2'b00};
    end
  end

  assign req_ready   = (st_q == WK_IDLE);
  assign mem_rd_en   = (st_q == WK_ISSUE);
  assign mem_rd_addr = rda_q;
  assign rsp_valid   = rv_q;
  assign rsp_fault   = rf_q;
  assign rsp_paddr   = rp_q;
  assign fill_tag    = addr_q[31:12];
  assign fill_pfn    = mem_rd_data[31:12];

endmodule

// File: rtl/aper_xlate.sv
`timescale 1ns/1ps
module aper_xlate
  import aper_pkg::*;
#(
  parameter int DIR_ENTRIES = 64,
  parameter int TLB_ENTRIES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_addr,
  output logic        rsp_valid,
  output logic        rsp_fault,
  output logic [31:0] rsp_paddr,
  output logic        mem_rd_en,
  output logic [31:0] mem_rd_addr,
  input  logic        mem_rd_valid,
  input  logic [31:0] mem_rd_data
);

  localparam int IDX_W = (DIR_ENTRIES > 1) ? $clog2(DIR_ENTRIES) : 1;

  logic [7:0]             size_code;
  logic [9:0]             base_hi;
  logic                   ctrl_armed;
  logic                   flush;
  dir_ent_t               dir_ent;
  logic [9:0]             dir_off;
  logic                   in_range;
  logic                   tlb_hit;
  logic [19:0]            tlb_pfn;
  logic                   fill_en;
  logic [19:0]            fill_tag, fill_pfn;
  logic [TLB_ENTRIES-1:0] tlb_vld;

  // wraps for addresses below the base, which then fail the limit check
  assign dir_off  = req_addr[31:22] - base_hi;
  assign in_range = (dir_off < 10'(slots_for_code(size_code))) &&
                    (dir_off < 10'(DIR_ENTRIES));

  aper_regs #(.DIR_ENTRIES(DIR_ENTRIES)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .cfg_wdata  (cfg_wdata),
    .rd_idx     (dir_off[IDX_W-1:0]),
    .size_code  (size_code),
    .base_hi    (base_hi),
    .ctrl_armed (ctrl_armed),
    .flush      (flush),
    .rd_ent     (dir_ent)
  );

  aper_tlb #(.ENTRIES(TLB_ENTRIES), .TAG_W(20), .PFN_W(20)) u_tlb (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .lk_tag   (req_addr[31:12]),
    .hit      (tlb_hit),
    .hit_pfn  (tlb_pfn),
    .fill_en  (fill_en),
    .fill_tag (fill_tag),
    .fill_pfn (fill_pfn),
    .vld      (tlb_vld)
  );

  aper_walk u_walk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_addr     (req_addr),
    .req_ready    (req_ready),
    .in_range     (in_range),
    .dir_ent      (dir_ent),
    .tlb_hit      (tlb_hit),
    .tlb_pfn      (tlb_pfn),
    .flush        (flush),
    .mem_rd_en    (mem_rd_en),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_data  (mem_rd_data),
    .rsp_valid    (rsp_valid),
    .rsp_fault    (rsp_fault),
    .rsp_paddr    (rsp_paddr),
    .fill_en      (fill_en),
    .fill_tag     (fill_tag),
    .fill_pfn     (fill_pfn)
  );

endmodule

// File: rtl/aper_xlate_chk.sv
`timescale 1ns/1ps
module aper_xlate_chk #(
  parameter int TLB_ENTRIES = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cfg_we,
  input logic [1:0]             cfg_sel,
  input logic [31:0]            cfg_wdata,
  input logic                   req_valid,
  input logic                   req_ready,
  input logic                   rsp_valid,
  input logic                   rsp_fault,
  input logic [31:0]            rsp_paddr,
  input logic                   mem_rd_en,
  input logic                   mem_rd_valid,
  input logic                   ctrl_armed,
  input logic [TLB_ENTRIES-1:0] tlb_vld
);

  // R12: a read request lasts exactly one cycle
  a_r12_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);

  // R12: no new request is taken while a walk is issuing
  a_r12_busy_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> !req_ready);

  // R7: returned data produces a response in the next cycle
  a_r7_rsp_after_data: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !req_ready && !mem_rd_en) |=> rsp_valid);

  // R12: every response has an accepted request or returned data behind it
  a_r12_rsp_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(req_valid && req_ready) || $past(mem_rd_valid)));

  // R6: faults carry a zero address
  a_r6_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == 32'h0));

  // R10: an arming control write leaves the cache empty
  a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (cfg_sel == 2'd2) && cfg_wdata[7] && !ctrl_armed)
      |=> (tlb_vld == '0));

endmodule

bind aper_xlate aper_xlate_chk #(.TLB_ENTRIES(TLB_ENTRIES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_we       (cfg_we),
  .cfg_sel      (cfg_sel),
  .cfg_wdata    (cfg_wdata),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .rsp_valid    (rsp_valid),
  .rsp_fault    (rsp_fault),
  .rsp_paddr    (rsp_paddr),
  .mem_rd_en    (mem_rd_en),
  .mem_rd_valid (mem_rd_valid),
  .ctrl_armed   (ctrl_armed),
  .tlb_vld      (tlb_vld)
);

// File: tb/tb_aper_xlate.sv
`timescale 1ns/1ps
module tb_aper_xlate;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_addr;
  logic        rsp_valid;
  logic        rsp_fault;
  logic [31:0] rsp_paddr;
  logic        mem_rd_en;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_valid;
  logic [31:0] mem_rd_data;

  int n_chk;
  int n_fail;
  int rd_count;
  int busy_viol;
  logic [31:0] last_rd_addr;
  logic [31:0] mem [logic [31:0]];

  aper_xlate dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_paddr(rsp_paddr), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  // memory answers one cycle after each read pulse
  always @(posedge clk) begin
    mem_rd_valid <= mem_rd_en;
    mem_rd_data  <= mem_rd_en ? mem_rd(mem_rd_addr) : 32'h0;
    if (mem_rd_en) begin
      rd_count     <= rd_count + 1;
      last_rd_addr <= mem_rd_addr;
    end
  end

  always @(negedge clk) begin
    if (rst_n && mem_rd_en && req_ready) busy_viol++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_flush();
    cfg_wr(2'd2, 32'h0000_2200);
    cfg_wr(2'd2, 32'h0000_2280);
  endtask

  task automatic wait_rsp(output logic f, output logic [31:0] pa, output int lat);
    int extra;
    lat = 1;
    while (!rsp_valid && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    f  = rsp_fault;
    pa = rsp_paddr;
    @(negedge clk);
    extra = rsp_valid ? 1 : 0;
    chk("R12 single response", 32'(extra), 32'd0);
  endtask

  task automatic xlate(input logic [31:0] a, output logic f, output logic [31:0] pa,
                       output int nrd, output int lat);
    int r0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    r0 = rd_count;
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    wait_rsp(f, pa, lat);
    nrd = rd_count - r0;
  endtask

  task automatic t_reset();
    logic f; logic [31:0] pa; int nrd, lat;
    chk("R1 req_ready", 32'(req_ready), 32'd1);
    chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R1 mem_rd_en", 32'(mem_rd_en), 32'd0);
    xlate(32'h0000_1000, f, pa, nrd, lat);
    chk("R1 empty directory fault", 32'(f), 32'd1);
    chk("R1 no read", 32'(nrd), 32'd0);
  endtask

  task automatic t_walk_and_hit();
    logic f; logic [31:0] pa; int nrd, lat;
    cfg_wr(2'd1, 32'h4000_0000);
    cfg_wr(2'd3, 32'h0010_0000 | 32'h100 | 32'h0C0 | 32'd0);
    cfg_wr(2'd3, 32'h0011_0000 | 32'h100 | 32'd1);
    xlate(32'h4000_3ABC, f, pa, nrd, lat);
    chk("R2 entry address", last_rd_addr, 32'h0010_000C);
    chk("R7 translated", pa, 32'h1234_5ABC);
    chk("R7 miss latency", 32'(lat), 32'd3);
    chk("R7 one read", 32'(nrd), 32'd1);
    xlate(32'h4000_3123, f, pa, nrd, lat);
    chk("R8 hit address", pa, 32'h1234_5123);
    chk("R8 hit latency", 32'(lat), 32'd1);
    chk("R8 hit no read", 32'(nrd), 32'd0);
    xlate(32'h4040_5010, f, pa, nrd, lat);
    chk("R2 slot1 entry address", last_rd_addr, 32'h0011_0014);
    chk("R4 slot1 translated", pa, 32'h6600_5010);
  endtask

  task automatic t_bad_entry();
    logic f; logic [31:0] pa; int nrd, lat;
    xlate(32'h4000_9FFF, f, pa, nrd, lat);
    chk("R6 invalid entry fault", 32'(f), 32'd1);
    chk("R6 fault address zero", pa, 32'h0);
    xlate(32'h4000_9000, f, pa, nrd, lat);
    chk("R6 fault not cached", 32'(nrd), 32'd1);
  endtask

  task automatic t_range();
    logic f; logic [31:0] pa; int nrd, lat;
    xlate(32'h3FFF_F000, f, pa, nrd, lat);
    chk("R4 below base fault", 32'(f), 32'd1);
    chk("R4 below base no read", 32'(nrd), 32'd0);
    cfg_wr(2'd0, 32'd56);
    xlate(32'h4200_0444, f, pa, nrd, lat);
    chk("R5 beyond 8 slots fault", 32'(f), 32'd1);
    chk("R5 beyond 8 slots no read", 32'(nrd), 32'd0);
    cfg_wr(2'd0, 32'd48);
    xlate(32'h4200_0444, f, pa, nrd, lat);
    chk("R3 absent slot fault", 32'(f), 32'd1);
    chk("R3 absent slot no read", 32'(nrd), 32'd0);
    cfg_wr(2'd3, 32'h0012_0000 | 32'h100 | 32'd8);
    xlate(32'h4200_0444, f, pa, nrd, lat);
    chk("R5 slot 8 within 16", pa, 32'h7770_0444);
    cfg_wr(2'd0, 32'd5);
    xlate(32'h4000_3ABC, f, pa, nrd, lat);
    chk("R5 unknown code faults cached page", 32'(f), 32'd1);
    chk("R5 unknown code no read", 32'(nrd), 32'd0);
    cfg_wr(2'd0, 32'd0);
  endtask

  task automatic t_invalidate();
    logic f; logic [31:0] pa; int nrd, lat;
    cfg_wr(2'd3, 32'h0011_0000 | 32'd1);
    xlate(32'h4040_6000, f, pa, nrd, lat);
    chk("R3 cleared slot fault", 32'(f), 32'd1);
    chk("R3 cleared slot no read", 32'(nrd), 32'd0);
    xlate(32'h4040_5010, f, pa, nrd, lat);
    chk("R3 cleared slot beats cache", 32'(f), 32'd1);
  endtask

  task automatic t_round_robin();
    logic f; logic [31:0] pa; int nrd, lat; int total;
    do_flush();
    total = 0;
    for (int i = 4; i <= 8; i++) begin
      xlate(32'h4000_0000 + (i << 12), f, pa, nrd, lat);
      total += nrd;
    end
    chk("R9 five distinct fills", 32'(total), 32'd5);
    xlate(32'h4000_5000, f, pa, nrd, lat);
    chk("R9 second fill kept", 32'(nrd), 32'd0);
    chk("R9 second fill data", pa, 32'h5000_5000);
    xlate(32'h4000_4000, f, pa, nrd, lat);
    chk("R9 oldest evicted", 32'(nrd), 32'd1);
  endtask

  task automatic t_flush();
    logic f; logic [31:0] pa; int nrd, lat;
    xlate(32'h4000_6000, f, pa, nrd, lat);
    chk("R10 page cached", 32'(nrd), 32'd0);
    cfg_wr(2'd2, 32'h0000_2280);
    xlate(32'h4000_6000, f, pa, nrd, lat);
    chk("R10 rewrite of set bit keeps cache", 32'(nrd), 32'd0);
    do_flush();
    xlate(32'h4000_6000, f, pa, nrd, lat);
    chk("R10 flush empties cache", 32'(nrd), 32'd1);
  endtask

  task automatic t_priority();
    logic f; logic [31:0] pa; int nrd, lat; int r0;
    cfg_wr(2'd2, 32'h0000_2200);
    @(negedge clk);
    r0 = rd_count;
    cfg_we = 1'b1; cfg_sel = 2'd2; cfg_wdata = 32'h0000_2280;
    req_valid = 1'b1; req_addr = 32'h4000_6000;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    wait_rsp(f, pa, lat);
    nrd = rd_count - r0;
    chk("R11 flush beats lookup", 32'(nrd), 32'd1);
    chk("R11 walk result", pa, 32'h5000_6000);
    xlate(32'h4000_6000, f, pa, nrd, lat);
    chk("R11 refilled after flush", 32'(nrd), 32'd0);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; rd_count = 0; busy_viol = 0;
    last_rd_addr = 32'h0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 2'd0; cfg_wdata = 32'h0;
    req_valid = 1'b0; req_addr = 32'h0;
    for (int i = 0; i < 16; i++) mem[32'h0010_0000 + 4 * i] = {20'h50000 + 20'(i), 12'h001};
    mem[32'h0010_000C] = 32'h1234_5001;
    mem[32'h0010_0024] = 32'h0000_0ABC;
    mem[32'h0011_0014] = 32'h6600_5001;
    mem[32'h0012_0000] = 32'h7770_0001;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_walk_and_hit();
    t_bad_entry();
    t_range();
    t_invalidate();
    t_round_robin();
    t_flush();
    t_priority();
    chk("R12 ready low during read", 32'(busy_viol), 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'd100000, 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule